// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Gate

This block sits between a running clock source and a set of differential clock outputs. It drives three true/complement output pairs from one source clock and passes a separate reference clock through. An active-low stop input parks every pair. Each pair can also be switched off through its own enable bit, which comes from a register file in the source clock domain. A parked pair holds its true leg low and its complement leg high. The reference output ignores the stop input and is controlled only by its own enable bit.

The stop request arrives asynchronously. It passes through a two-flop synchronizer clocked on rising source edges. A gate register updated on falling source edges then combines it with the enable bits. The gate changes only while the source clock is low, so entering or leaving the parked state never cuts a pulse short. After release, the first thing each pair shows is a full-width high phase on its true leg. The reference path uses the same structure in the reference clock domain.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every true output is 0, every complement output is 1 and `ref_out` is 0.
- R2: When `stop_n` falls, all pairs park with true = 0 and complement = 1. Pairs keep running through the first two rising `src_clk` edges after the change and are parked from the third rising edge on.
- R3: With `stop_n` = 1 and `pair_en[i]` = 1, `clk_t[i]` follows `src_clk`. After `stop_n` rises, every pair stays parked through the first two rising edges and runs from the third.
- R4: Bit i of `pair_en` controls pair i. A 0 parks that pair at the same levels as a stop and leaves the other pairs unchanged. A change in `pair_en` shows from the second rising `src_clk` edge after it.
- R5: When `ref_en` = 1, `ref_out` follows `ref_clk` whatever the value of `stop_n`. When `ref_en` = 0, `ref_out` is held at 0. A change in `ref_en` shows from the third rising `ref_clk` edge after it.
- R6: The gate switches only on falling source edges. The first high phase after release is high at both its start and its end. The last high phase before parking is also a full-width pulse.
- R7: `clk_c[i]` is always the inverse of `clk_t[i]`, in both the running and the parked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Running source clock for the pairs |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous stop request, 0 = stop pairs |
| pair_en | input | NPAIR | Per-pair enable, bit i for pair i |
| ref_en | input | 1 | Reference output enable |
| clk_t | output | NPAIR | True legs |
| clk_c | output | NPAIR | Complement legs |
| ref_out | output | 1 | Gated reference clock |

## Verification
The bench changes `stop_n` and the enable bits just after a falling edge. It then samples in the high phase that follows the required rising edge: the third edge for `stop_n`, the second for `pair_en`, and the third `ref_clk` edge for `ref_en`. The latency checks also sample the high phases just before the due edge, to show the change did not arrive early. Sampling once near the start and once near the end of a high phase confirms the full-width pulse. Every combination of stop state and enable pattern is swept, and each is checked in both clock phases.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int NPAIR = 3,
  parameter int SYNC  = 2
) (
  input  logic             src_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             stop_n,
  input  logic [NPAIR-1:0] pair_en,
  input  logic             ref_en,
  output logic [NPAIR-1:0] clk_t,
  output logic [NPAIR-1:0] clk_c,
  output logic             ref_out
);

  logic [SYNC-1:0]  run_sync;
  logic [SYNC-1:0]  ref_sync;
  logic [NPAIR-1:0] gate;
  logic             ref_gate;
  logic             run_ok;

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) run_sync <= '0;
    else        run_sync <= {run_sync[SYNC-2:0], stop_n};

  assign run_ok = run_sync[SYNC-1];

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) gate <= '0;
    else        gate <= {NPAIR{run_ok}} & pair_en;

  assign clk_t = gate & {NPAIR{src_clk}};
  assign clk_c = ~clk_t;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_sync <= '0;
    else        ref_sync <= {ref_sync[SYNC-2:0], ref_en};

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) ref_gate <= 1'b0;
    else        ref_gate <= ref_sync[SYNC-1];

  assign ref_out = ref_clk & ref_gate;

  // R2
  park_on_stop_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
    !$past(run_ok) |-> (clk_t == '0 && clk_c == '1));

  for (genvar i = 0; i < NPAIR; i++) begin : g_chk
    // R4
    pair_disable_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
      !$past(pair_en[i]) |-> (!clk_t[i] && clk_c[i]));
    // R3
    pair_run_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
      ($past(run_ok) && $past(pair_en[i])) |-> (clk_t[i] && !clk_c[i]));
  end

  // R5
  ref_run_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    $past(ref_sync[SYNC-1]) |-> ref_out);

  // R5
  ref_hold_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    !$past(ref_sync[SYNC-1]) |-> !ref_out);

endmodule

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  logic       src_clk = 0, ref_clk = 0, rst_n = 0, stop_n = 1, ref_en = 1;
  logic [2:0] pair_en = 3'b111;
  logic [2:0] clk_t, clk_c;
  logic       ref_out;
  int pass_n = 0, tot_n = 0;
  bit done = 0;

  always #5 src_clk = ~src_clk;
  always #7 ref_clk = ~ref_clk;

  clk_stop_gate u_dut (.src_clk, .ref_clk, .rst_n, .stop_n, .pair_en, .ref_en,
                       .clk_t, .clk_c, .ref_out);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tot_n++;
    if (act === exp) pass_n++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic pair_chk(string req, logic [2:0] exp);
    chk(req, {2'b0, clk_c, clk_t}, {2'b0, ~exp, exp});
  endtask

  task automatic hi(int n);
    repeat (n) @(posedge src_clk);
    #2;
  endtask

  task automatic settle();
    @(negedge src_clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", pass_n, tot_n);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    tot_n++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    hi(3);
    pair_chk("R1", 3'b000);
    chk("R1 ref", {7'b0, ref_out}, 8'd0);
    settle(); rst_n = 1;
    hi(3);
    pair_chk("R3 after reset", 3'b111);

    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 8; e++) begin
        settle();
        stop_n = s[0]; pair_en = e[2:0];
        hi(3);
        pair_chk(s ? "R4 sweep high" : "R2 sweep high", s ? e[2:0] : 3'b000);
        @(negedge src_clk); #2;
        pair_chk("R7 sweep low", 3'b000);
      end

    settle(); stop_n = 0; pair_en = 3'b111;
    hi(3);
    pair_chk("R2 parked", 3'b000);
    settle(); stop_n = 1;
    hi(1); pair_chk("R3 not early 1", 3'b000);
    hi(1); pair_chk("R3 not early 2", 3'b000);
    @(posedge src_clk); #1;
    pair_chk("R3 due", 3'b111);
    #3;
    pair_chk("R6 full width end", 3'b111);

    settle(); stop_n = 0;
    hi(1); pair_chk("R2 still running 1", 3'b111);
    #2.5; pair_chk("R6 last pulse end", 3'b111);
    hi(1); pair_chk("R2 still running 2", 3'b111);
    hi(1); pair_chk("R2 due", 3'b000);

    settle(); stop_n = 1;
    hi(3);
    settle(); pair_en = 3'b101;
    hi(1); pair_chk("R4 not early", 3'b111);
    hi(1); pair_chk("R4 due", 3'b101);

    settle(); stop_n = 0; ref_en = 1;
    repeat (3) begin
      @(posedge ref_clk); #2;
      chk("R5 ref high during stop", {7'b0, ref_out}, 8'd1);
      @(negedge ref_clk); #2;
      chk("R5 ref low phase", {7'b0, ref_out}, 8'd0);
    end
    settle(); ref_en = 0;
    repeat (3) @(posedge ref_clk);
    #2; chk("R5 ref disabled", {7'b0, ref_out}, 8'd0);
    settle(); ref_en = 1;
    repeat (3) @(posedge ref_clk);
    #2; chk("R5 ref enabled", {7'b0, ref_out}, 8'd1);

    finish_run();
  end
endmodule